// File: doc/BRIEF.md
# Banked Cartridge ROM/RAM Mapper

This block sits between an 8-bit CPU bus and the cartridge memories. It turns writes to the CPU's ROM address space into bank-control updates. CPU writes below 0x8000 never reach the ROM. Instead, bits [15:13] of the write address pick one of four control regions. From the resulting state, the block forms the full ROM address for two windows. The fixed window covers CPU 0x0000-0x3FFF and the switchable window covers 0x4000-0x7FFF. It also forms the external RAM address for the 8 KiB window at 0xA000-0xBFFF, and it gates RAM writes and reads on a software-controlled enable.

The bank state is a 5-bit low field, a 2-bit high field and a banking-mode bit. The high field is placed above the low field at bit 5. A multicart build places it at bit 4 instead, and then only 4 low bits are kept. In mode 1 the high field also drives the fixed window and the RAM bank. In mode 0 both of those are forced to bank 0. ROM and RAM sizes are powers of two, set by parameters. Bank numbers that run past the end of a memory wrap by masking the byte offset.

Top module: `cart_bank_mapper`

## Requirements
- R1: After reset the low field is 1, the high field is 0, the mode is 0 and RAM is disabled. So CPU 0x4000 maps to ROM byte 0x4000, CPU 0x0000 maps to ROM byte 0, and the RAM bank is 0.
- R2: Bank state changes only on a write (cpu_wr high at a rising clock edge) with cpu_addr[15]=0. Writes to 0x8000 and above leave all mapping unchanged.
- R3: A write to region 0 (cpu_addr[15:13]=000) with data 0x0A enables RAM, and data 0x00 disables it. Any other data leaves the enable as it was.
- R4: A write to region 1 (001) loads data[4:0] into the low field, with 0 replaced by 1. The result is then masked to the stride width (5 bits, or 4 bits in multicart). The high field is unchanged.
- R5: A write to region 2 (010) loads data[1:0] into the high field. The switchable bank is (high << stride) | low, with stride 5, or 4 in multicart.
- R6: A write to region 3 (011) sets the mode from data[0]. In mode 1 the fixed-window bank is high << stride and the RAM bank is high. In mode 0 both are 0.
- R7: The ROM byte address is (bank*16384 + cpu_addr[13:0]) masked with ROM_BYTES-1.
- R8: The RAM byte address is (ram_bank*8192 + cpu_addr[12:0]) masked with RAM_BYTES-1.
- R9: cpu_addr[14]=0 selects the fixed-window bank and cpu_addr[14]=1 selects the switchable bank.
- R10: RAM window accesses (cpu_addr[15:13]=101) use the RAM bank from R6.
- R11: ram_we is high only for a write in the RAM window while RAM is enabled. cpu_rdata returns rom_rdata for cpu_addr[15]=0. It returns ram_rdata in the RAM window when enabled, and 0xFF otherwise.
- R12: With MULTICART=1 a low-field value of 0x10 becomes bank 0 in the low field, since the zero check comes before the 4-bit mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_wr | input | 1 | CPU write strobe, one cycle per write |
| rom_rdata | input | 8 | Data from the external ROM |
| ram_rdata | input | 8 | Data from the external RAM |
| cpu_rdata | output | 8 | Read data returned to the CPU |
| rom_addr | output | ROM_AW | ROM byte address |
| ram_addr | output | RAM_AW | RAM byte address |
| ram_we | output | 1 | External RAM write enable |
| ram_active | output | 1 | RAM enable state |

## Verification
Three instances share one bus: a full-size one, a small one that wraps ROM and RAM banks, and a multicart one. Each write is therefore checked against three different mappings at once.

The bench checks the following corner cases, and what a wrong design would show:
- **Zero-to-one remap of the low field.** Without it, the switchable window would alias the fixed window.
- **The multicart ordering of remap and then mask.** With the order reversed, 0x10 would select bank 1 and not bank 0.
- **Mode switching.** A design that forgot to force bank 0 in mode 0 would send RAM accesses to the wrong bank.
- **Non-key enable values.** A design that treated these as "disable" would lose RAM access.
- **Wrap on an undersized memory.** Without wrapping, the address would run past the end of the array.

// File: rtl/cart_map_pkg.sv
package cart_map_pkg;

  typedef enum logic [1:0] {
    RG_RAMGATE = 2'd0,
    RG_BANKLO  = 2'd1,
    RG_BANKHI  = 2'd2,
    RG_MODE    = 2'd3
  } ctl_region_e;

  localparam logic [7:0] RAM_ON_KEY  = 8'h0A;
  localparam logic [7:0] RAM_OFF_KEY = 8'h00;
  localparam logic [2:0] RAM_WIN_TAG = 3'b101;

  // Place the high field above the low field at the stride position.
  function automatic logic [6:0] join_bank(input logic [1:0] hi,
                                           input logic [4:0] lo,
                                           input bit         quad);
    if (quad) join_bank = {1'b0, hi, lo[3:0]};
    else      join_bank = {hi, lo};
  endfunction

endpackage

// File: rtl/cmap_ctrl_regs.sv
module cmap_ctrl_regs
  import cart_map_pkg::*;
#(
  parameter bit MULTICART = 1'b0
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       bus_wr,
  input  logic [2:0] bus_top,
  input  logic [7:0] wdata,
  output logic [4:0] lo_q,
  output logic [1:0] hi_q,
  output logic       mode_q,
  output logic       ram_on_q
);

  localparam logic [4:0] LO_MASK = MULTICART ? 5'h0F : 5'h1F;

  logic        wr_en;
  ctl_region_e region;
  logic [4:0]  lo_raw;
  logic [4:0]  lo_next;

  assign wr_en  = bus_wr && !bus_top[2];
  assign region = ctl_region_e'(bus_top[1:0]);

  // Remap zero before masking; the multicart mask may then yield zero.
  always_comb begin
    lo_raw  = (wdata[4:0] == 5'd0) ? 5'd1 : wdata[4:0];
    lo_next = lo_raw & LO_MASK;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_q     <= 5'd1;
      hi_q     <= 2'd0;
      mode_q   <= 1'b0;
      ram_on_q <= 1'b0;
    end else if (wr_en) begin
      unique case (region)
        RG_RAMGATE: begin
          if (wdata == RAM_ON_KEY)       ram_on_q <= 1'b1;
          else if (wdata == RAM_OFF_KEY) ram_on_q <= 1'b0;
        end
        RG_BANKLO: lo_q   <= lo_next;
        RG_BANKHI: hi_q   <= wdata[1:0];
        RG_MODE:   mode_q <= wdata[0];
        default: ;
      endcase
    end
  end

  // R1
  reset_state_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (lo_q == 5'd1 && hi_q == 2'd0 && !mode_q && !ram_on_q));

  // R2
  bank_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable({lo_q, hi_q, mode_q, ram_on_q}));

  // R3
  ram_key_on_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && region == RG_RAMGATE && wdata == RAM_ON_KEY) |=> ram_on_q);

  // R3
  ram_key_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && region == RG_RAMGATE && wdata != RAM_ON_KEY && wdata != RAM_OFF_KEY)
      |=> $stable(ram_on_q));

  // R4
  lo_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
    MULTICART || (lo_q != 5'd0));

endmodule

// File: rtl/cmap_addr_gen.sv
module cmap_addr_gen
  import cart_map_pkg::*;
#(
  parameter int ROM_BYTES = 2097152,
  parameter int RAM_BYTES = 32768,
  parameter bit MULTICART = 1'b0,
  localparam int ROM_AW = $clog2(ROM_BYTES),
  localparam int RAM_AW = $clog2(RAM_BYTES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [14:0]       cpu_addr,
  input  logic [4:0]        lo_i,
  input  logic [1:0]        hi_i,
  input  logic              mode_i,
  output logic [ROM_AW-1:0] rom_addr,
  output logic [RAM_AW-1:0] ram_addr
);

  localparam logic [ROM_AW-1:0] ROM_MASK = ROM_AW'(ROM_BYTES - 1);
  localparam logic [RAM_AW-1:0] RAM_MASK = RAM_AW'(RAM_BYTES - 1);

  logic [6:0] sw_bank;
  logic [6:0] fix_bank;
  logic [1:0] ram_bank;
  logic [6:0] sel_bank;

  always_comb begin
    sw_bank  = join_bank(hi_i, lo_i, MULTICART);
    fix_bank = mode_i ? join_bank(hi_i, 5'd0, MULTICART) : 7'd0;
    ram_bank = mode_i ? hi_i : 2'd0;
    sel_bank = cpu_addr[14] ? sw_bank : fix_bank;
    rom_addr = ROM_AW'({sel_bank, cpu_addr[13:0]}) & ROM_MASK;
    ram_addr = RAM_AW'({ram_bank, cpu_addr[12:0]}) & RAM_MASK;
  end

  // R6
  mode0_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !mode_i |-> (fix_bank == 7'd0 && ram_bank == 2'd0));

endmodule

// File: rtl/cmap_data_path.sv
module cmap_data_path
  import cart_map_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] bus_top,
  input  logic       cpu_wr,
  input  logic       ram_on_i,
  input  logic [7:0] rom_rdata,
  input  logic [7:0] ram_rdata,
  output logic [7:0] cpu_rdata,
  output logic       ram_we
);

  logic in_ram_win;

  always_comb begin
    in_ram_win = (bus_top == RAM_WIN_TAG);
    ram_we     = cpu_wr && in_ram_win && ram_on_i;
    if (!bus_top[2])                 cpu_rdata = rom_rdata;
    else if (in_ram_win && ram_on_i) cpu_rdata = ram_rdata;
    else                             cpu_rdata = 8'hFF;
  end

  // R11
  ram_off_read_chk: assert property (@(posedge clk) disable iff (rst)
    (in_ram_win && !ram_on_i) |-> (cpu_rdata == 8'hFF && !ram_we));

endmodule

// File: rtl/cart_bank_mapper.sv
module cart_bank_mapper #(
  parameter int ROM_BYTES = 2097152,
  parameter int RAM_BYTES = 32768,
  parameter bit MULTICART = 1'b0,
  localparam int ROM_AW = $clog2(ROM_BYTES),
  localparam int RAM_AW = $clog2(RAM_BYTES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [15:0]       cpu_addr,
  input  logic [7:0]        cpu_wdata,
  input  logic              cpu_wr,
  input  logic [7:0]        rom_rdata,
  input  logic [7:0]        ram_rdata,
  output logic [7:0]        cpu_rdata,
  output logic [ROM_AW-1:0] rom_addr,
  output logic [RAM_AW-1:0] ram_addr,
  output logic              ram_we,
  output logic              ram_active
);

  logic [4:0] lo_q;
  logic [1:0] hi_q;
  logic       mode_q;
  logic       ram_on_q;

  cmap_ctrl_regs #(.MULTICART(MULTICART)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .bus_wr   (cpu_wr),
    .bus_top  (cpu_addr[15:13]),
    .wdata    (cpu_wdata),
    .lo_q     (lo_q),
    .hi_q     (hi_q),
    .mode_q   (mode_q),
    .ram_on_q (ram_on_q)
  );

  cmap_addr_gen #(
    .ROM_BYTES (ROM_BYTES),
    .RAM_BYTES (RAM_BYTES),
    .MULTICART (MULTICART)
  ) u_addr (
    .clk      (clk),
    .rst      (rst),
    .cpu_addr (cpu_addr[14:0]),
    .lo_i     (lo_q),
    .hi_i     (hi_q),
    .mode_i   (mode_q),
    .rom_addr (rom_addr),
    .ram_addr (ram_addr)
  );

  cmap_data_path u_data (
    .clk       (clk),
    .rst       (rst),
    .bus_top   (cpu_addr[15:13]),
    .cpu_wr    (cpu_wr),
    .ram_on_i  (ram_on_q),
    .rom_rdata (rom_rdata),
    .ram_rdata (ram_rdata),
    .cpu_rdata (cpu_rdata),
    .ram_we    (ram_we)
  );

  assign ram_active = ram_on_q;

endmodule

// File: tb/tb_cart_bank_mapper.sv
`timescale 1ns/1ps
module tb_cart_bank_mapper;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] cpu_addr = 16'h0;
  logic [7:0]  cpu_wdata = 8'h0;
  logic        cpu_wr = 1'b0;
  logic [7:0]  rom_rdata = 8'h00;
  logic [7:0]  ram_rdata = 8'h00;

  logic [7:0]  rd_a, rd_s, rd_m;
  logic [20:0] rom_a; logic [18:0] rom_s; logic [19:0] rom_m;
  logic [14:0] ram_a; logic [13:0] ram_s; logic [12:0] ram_m;
  logic        we_a, we_s, we_m, on_a, on_s, on_m;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  cart_bank_mapper #(.ROM_BYTES(2097152), .RAM_BYTES(32768), .MULTICART(1'b0)) dut (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_wr(cpu_wr),
    .rom_rdata(rom_rdata), .ram_rdata(ram_rdata), .cpu_rdata(rd_a),
    .rom_addr(rom_a), .ram_addr(ram_a), .ram_we(we_a), .ram_active(on_a));

  cart_bank_mapper #(.ROM_BYTES(524288), .RAM_BYTES(16384), .MULTICART(1'b0)) dut_sm (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_wr(cpu_wr),
    .rom_rdata(rom_rdata), .ram_rdata(ram_rdata), .cpu_rdata(rd_s),
    .rom_addr(rom_s), .ram_addr(ram_s), .ram_we(we_s), .ram_active(on_s));

  cart_bank_mapper #(.ROM_BYTES(1048576), .RAM_BYTES(8192), .MULTICART(1'b1)) dut_mc (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_wr(cpu_wr),
    .rom_rdata(rom_rdata), .ram_rdata(ram_rdata), .cpu_rdata(rd_m),
    .rom_addr(rom_m), .ram_addr(ram_m), .ram_we(we_m), .ram_active(on_m));

  // {write addr, write data, probe addr, expected rom_addr of dut}
  localparam logic [60:0] VEC [12] = '{
    {16'h2000, 8'h00, 16'h4000, 21'h004000},  // R4 zero remaps to one
    {16'h2100, 8'h05, 16'h4123, 21'h014123},  // R4 R9
    {16'h3FFF, 8'h1F, 16'h7FFF, 21'h07FFFF},  // R4 top of low field
    {16'h2000, 8'hE0, 16'h4000, 21'h004000},  // R4 only bits 4:0 used
    {16'h4000, 8'h02, 16'h4000, 21'h104000},  // R5 high field at bit 5
    {16'h2000, 8'h03, 16'h4010, 21'h10C010},  // R5 low kept with high
    {16'h0000, 8'h00, 16'h1234, 21'h001234},  // R6 mode 0 fixed window
    {16'h6000, 8'h01, 16'h0100, 21'h100100},  // R6 mode 1 fixed window
    {16'h5FFF, 8'hFD, 16'h0000, 21'h080000},  // R5 R6 high from data 1:0
    {16'h6000, 8'hFE, 16'h3FFF, 21'h003FFF},  // R6 mode from bit 0
    {16'h8000, 8'h1F, 16'h4000, 21'h08C000},  // R2 write above 0x7FFF ignored
    {16'hA000, 8'h07, 16'h4001, 21'h08C001}   // R2 RAM-window write ignored
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
    @(negedge clk);
    cpu_wr = 1'b0;
  endtask

  task automatic probe(input logic [15:0] a);
    @(negedge clk);
    cpu_addr = a;
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; cpu_wr = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : main
    do_reset();
    // R1 reset state
    probe(16'h4000);
    chk("R1 sw bank", 32'(rom_a), 32'h4000);
    chk("R1 sw bank mc", 32'(rom_m), 32'h4000);
    probe(16'h0000);
    chk("R1 fixed bank", 32'(rom_a), 32'h0);
    chk("R1 ram off", 32'(on_a), 32'h0);
    ram_rdata = 8'h5A;
    probe(16'hA000);
    chk("R1 ram bank 0", 32'(ram_a), 32'h0);
    chk("R1 read while off", 32'(rd_a), 32'hFF);

    for (int i = 0; i < 12; i++) begin
      logic [60:0] v;
      v = VEC[i];
      wr(v[60:45], v[44:37]);
      probe(v[36:21]);
      chk($sformatf("vector %0d rom_addr", i), 32'(rom_a), 32'(v[20:0]));
    end

    do_reset();
    // R3 enable keys
    wr(16'h0000, 8'h0A);  #1; chk("R3 enable", 32'(on_a), 32'h1);
    chk("R3 enable mc", 32'(on_m), 32'h1);
    wr(16'h1FFF, 8'h55);  #1; chk("R3 other value keeps on", 32'(on_a), 32'h1);
    wr(16'h0000, 8'h00);  #1; chk("R3 disable", 32'(on_a), 32'h0);
    wr(16'h0000, 8'h0B);  #1; chk("R3 other value keeps off", 32'(on_a), 32'h0);
    wr(16'h1000, 8'h0A);  #1; chk("R3 enable again", 32'(on_a), 32'h1);

    // R11 data gating
    ram_rdata = 8'h3C; rom_rdata = 8'hC3;
    probe(16'hA010); chk("R11 ram read on", 32'(rd_a), 32'h3C);
    probe(16'h4000); chk("R11 rom read", 32'(rd_a), 32'hC3);
    @(negedge clk); cpu_addr = 16'hA010; cpu_wdata = 8'h99; cpu_wr = 1'b1; #1;
    chk("R11 ram_we on", 32'(we_a), 32'h1);
    @(negedge clk); cpu_wr = 1'b0;
    wr(16'h0000, 8'h00);
    probe(16'hA010); chk("R11 ram read off", 32'(rd_a), 32'hFF);
    @(negedge clk); cpu_addr = 16'hA010; cpu_wr = 1'b1; #1;
    chk("R11 ram_we off", 32'(we_a), 32'h0);
    @(negedge clk); cpu_wr = 1'b0;
    probe(16'hC000); chk("R11 unmapped read", 32'(rd_a), 32'hFF);
    wr(16'h0000, 8'h0A);

    // R10 R8 RAM bank in mode 1 with wrap
    wr(16'h6000, 8'h01);
    wr(16'h4000, 8'h03);
    probe(16'hA123);
    chk("R10 ram bank 3", 32'(ram_a), 32'h6123);
    chk("R8 ram wrap 2 banks", 32'(ram_s), 32'h2123);
    chk("R8 ram wrap 1 bank", 32'(ram_m), 32'h0123);
    probe(16'h0000);
    chk("R6 fixed bank mode 1", 32'(rom_a), 32'h180000);
    wr(16'h6000, 8'h00);
    probe(16'hA123); chk("R6 ram bank forced 0", 32'(ram_a), 32'h0123);
    probe(16'h0000); chk("R6 fixed forced 0", 32'(rom_a), 32'h0);

    // R7 ROM wrap
    probe(16'h4000);
    chk("R7 full rom", 32'(rom_a), 32'h184000);
    chk("R7 wrapped rom", 32'(rom_s), 32'h04000);
    chk("R12 mc sw bank", 32'(rom_m), 32'hC4000);
    wr(16'h6000, 8'h01);
    probe(16'h0000);
    chk("R7 wrapped fixed", 32'(rom_s), 32'h0);
    chk("R12 mc fixed", 32'(rom_m), 32'hC0000);

    // R12 multicart low field
    wr(16'h2000, 8'h12);
    probe(16'h4000);
    chk("R12 mc mask", 32'(rom_m), 32'hC8000);
    chk("R4 low kept 5 bits", 32'(rom_a), 32'h1C8000);
    wr(16'h2000, 8'h10);
    probe(16'h4000);
    chk("R12 mc 0x10 to bank 0", 32'(rom_m), 32'hC0000);
    chk("R4 0x10 in full", 32'(rom_a), 32'h1C0000);
    probe(16'h7ABC);
    chk("R9 switchable offset", 32'(rom_a), 32'h1C3ABC);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule